// File: doc/BRIEF.md
# Framed Four-Bit Serial Pattern Detector

This block watches a serial bit stream, one bit per accepted cycle, and cuts it into fixed frames of four bits. A frame starts with the first accepted bit after reset. The next frame starts after every fourth accepted bit, whether or not the frame just closed was a match. When the four bits of a frame, read with the earliest bit as the most significant, form one of the two target words, the block raises `hit` for the closing bit. The two words are 0101 and 1001, and both are parameters. Matches that straddle a frame boundary are never reported.

A bit is taken only in cycles where `bit_vld` is high. The producer may therefore stall at any point inside a frame without disturbing the alignment. Once the leading bits of a frame rule out both target words, for example 00 or 11, the frame still runs to its fourth bit on a dead path before the next frame begins. The parameter `REG_OUT` selects one of two output forms. With `REG_OUT` = 0 the output is combinational: `hit` is high in the same cycle as the fourth bit. With `REG_OUT` = 1 the output is registered: `hit` is high in the cycle after that bit.

Top module: `fdet_framed`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `hit` is 0, and the first accepted bit after reset is bit 1 of a frame.
- R2: A frame received as 0, 1, 0, 1 (earliest bit first, word 4'b0101) gives `hit` = 1 for its fourth bit.
- R3: A frame received as 1, 0, 0, 1 (word 4'b1001) gives `hit` = 1 for its fourth bit.
- R4: Every frame whose word is neither 4'b0101 nor 4'b1001 gives `hit` = 0 for its fourth bit.
- R5: Detection is aligned to frames only. The stream 1101 0111 contains 0101 across the frame boundary, and `hit` stays 0 throughout.
- R6: `hit` is 0 for bits 1 to 3 of every frame. In combinational mode it is 0 in every cycle where `bit_vld` is low.
- R7: A cycle with `bit_vld` low consumes no bit. It changes neither the frame position nor the partial match, so stalls inside a frame do not change the result.
- R8: After the fourth bit the block returns to the start of a frame, whether or not the frame matched. Two matching frames in a row each give their own single-cycle `hit`.
- R9: A frame whose first two bits are 00 or 11 takes the dead path. It still ends after four bits, never gives `hit`, and the frame after it is judged normally.
- R10: With `REG_OUT` = 1, `hit` is the combinational result delayed by exactly one clock cycle, and it stays high for one cycle per match.
- R11: Asserting reset in the middle of a frame discards the partial frame. The next accepted bit starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | High when `bit_in` holds a bit to consume |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Match flag for the fourth bit of a matching frame |

## Verification
All sixteen four-bit frames are sent one after another. This separates the two matching words from the fourteen non-matching ones, and it separates the dead-path prefixes 00 and 11 from the live prefixes 01 and 10. A stream that holds 0101 only across a frame boundary shows whether detection follows frame alignment or slides bit by bit. A frame with stalls inside it, a mid-frame reset and two matching frames back to back show that invalid cycles, resets and frame ends each move the alignment correctly. A long random stream with random `bit_vld` gaps then runs through both the combinational and the registered variants. It is checked against a bench model of frame position and frame contents, which also confirms the one-cycle offset of the registered form.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    // Frame geometry and number of target words
    localparam int FRAME_BITS = 4;
    localparam int NUM_PAT    = 2;
    localparam int SLOT_W     = $clog2(FRAME_BITS);
    localparam int LAST_SLOT  = FRAME_BITS - 1;

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [NUM_PAT-1:0] alive_t;

    // Frame position register contents
    typedef struct packed {
        slot_t slot;
    } pos_st_t;

    // Per-word "still possible" flags for the frame in progress
    typedef struct packed {
        alive_t alive;
    } trk_st_t;

endpackage

// File: rtl/fdet_slot_ctr.sv
module fdet_slot_ctr
    import fdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output slot_t slot_o,
    output logic  last_o
);

    pos_st_t pos_d, pos_q;

    always_comb begin
        pos_d  = pos_q;
        last_o = (pos_q.slot == slot_t'(LAST_SLOT));
        if (adv) begin
            if (last_o) pos_d.slot = '0;
            else        pos_d.slot = pos_q.slot + slot_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign slot_o = pos_q.slot;

endmodule

// File: rtl/fdet_track.sv
module fdet_track
    import fdet_pkg::*;
#(
    parameter logic [NUM_PAT-1:0][FRAME_BITS-1:0] PATS = {4'b1001, 4'b0101}
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  logic  bit_in,
    input  slot_t slot_i,
    input  logic  last_i,
    output logic  hit_now
);

    // Patterns with bit order reversed so that slot k indexes the k-th received bit
    logic [NUM_PAT-1:0][FRAME_BITS-1:0] pat_rev;
    alive_t bit_ok;

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
        for (genvar k = 0; k < FRAME_BITS; k++) begin : g_bit
            assign pat_rev[p][k] = PATS[p][FRAME_BITS-1-k];
        end
        assign bit_ok[p] = (bit_in == pat_rev[p][slot_i]);
    end

    trk_st_t trk_d, trk_q;

    always_comb begin
        trk_d   = trk_q;
        hit_now = 1'b0;
        if (adv) begin
            if (last_i) begin
                hit_now     = |(trk_q.alive & bit_ok);
                trk_d.alive = '1;              // next frame starts fresh
            end else begin
                trk_d.alive = trk_q.alive & bit_ok; // all zero: dead path
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{alive: '1};
        else        trk_q <= trk_d;
    end

endmodule

// File: rtl/fdet_out.sv
module fdet_out #(
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_now,
    output logic hit_o
);

    if (REG_OUT) begin : g_reg
        logic hit_d, hit_q;
        always_comb hit_d = hit_now;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= hit_d;
        end
        assign hit_o = hit_q;
    end else begin : g_comb
        assign hit_o = hit_now;
    end

endmodule

// File: rtl/fdet_framed.sv
module fdet_framed
    import fdet_pkg::*;
#(
    parameter logic [NUM_PAT-1:0][FRAME_BITS-1:0] PATS = {4'b1001, 4'b0101},
    parameter bit REG_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic hit
);

    slot_t slot_q;
    logic  last_slot;
    logic  hit_now;

    fdet_slot_ctr u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (bit_vld),
        .slot_o (slot_q),
        .last_o (last_slot)
    );

    fdet_track #(.PATS(PATS)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_vld),
        .bit_in  (bit_in),
        .slot_i  (slot_q),
        .last_i  (last_slot),
        .hit_now (hit_now)
    );

    fdet_out #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_now (hit_now),
        .hit_o   (hit)
    );

endmodule

// File: rtl/fdet_checker.sv
module fdet_checker
    import fdet_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input logic  clk,
    input logic  rst_n,
    input logic  bit_vld,
    input logic  hit,
    input slot_t slot
);

    AST_STALL_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(slot)) else $error("slot moved on idle cycle"); // R7

    AST_FRAME_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && slot == slot_t'(LAST_SLOT)) |=> (slot == '0)) else $error("no wrap"); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit) else $error("hit longer than one cycle"); // R10

    if (REG_OUT) begin : g_reg_chk
        AST_REG_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (slot == '0)) else $error("registered hit off frame start"); // R10
    end else begin : g_comb_chk
        AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> bit_vld) else $error("hit without valid bit"); // R6
        AST_HIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (slot == slot_t'(LAST_SLOT))) else $error("hit before fourth bit"); // R6
    end

endmodule

bind fdet_framed fdet_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .hit     (hit),
    .slot    (slot_q)
);

// File: tb/sim_fdet_framed.sv
`timescale 1ns/1ps
module sim_fdet_framed;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic hit0, hit1;

    int n_chk = 0;
    int n_err = 0;

    // bench model of frame position and contents
    int       m_pos = 0;
    logic [3:0] m_sh = '0;

    always #2.5 clk = ~clk;

    fdet_framed #(.REG_OUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit0)
    );

    fdet_framed #(.REG_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit1)
    );

    function automatic logic is_match(logic [3:0] w);
        return (w == 4'b0101) || (w == 4'b1001);
    endfunction

    function automatic string frame_tag(logic [3:0] w);
        if (w == 4'b0101) return "R2";
        if (w == 4'b1001) return "R3";
        if (w[3:2] == 2'b00 || w[3:2] == 2'b11) return "R9";
        return "R4";
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: hit=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle of stimulus; tag_last names the check of a fourth bit
    task automatic send(input logic v, input logic b, input string tag_last);
        logic exp;
        string tag;
        @(negedge clk);
        bit_vld = v;
        bit_in  = b;
        exp = v && (m_pos == 3) && is_match({m_sh[2:0], b});
        tag = (v && m_pos == 3) ? tag_last : "R6";
        #1 check(hit0, exp, tag);
        @(posedge clk);
        if (v) begin
            m_sh  = {m_sh[2:0], b};
            m_pos = (m_pos + 1) % 4;
        end
        #1 check(hit1, exp, "R10");
    endtask

    task automatic send_word(input logic [3:0] w, input string tag);
        for (int i = 3; i >= 0; i--) send(1'b1, w[i], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_vld = 1'b0;
        m_pos = 0;
        m_sh = '0;
        repeat (3) begin
            @(negedge clk);
            check(hit0, 1'b0, "R1");
            check(hit1, 1'b0, "R1");
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(hit0, 1'b0, "R1");
        check(hit1, 1'b0, "R1");
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R1: first accepted bits after reset form frame 1
        send_word(4'b0101, "R1");

        // every frame value, back to back (R2, R3, R4, R9)
        for (int f = 0; f < 16; f++) send_word(4'(f), frame_tag(4'(f)));

        // R8: matching frames in a row each give a hit
        send_word(4'b1001, "R8");
        send_word(4'b0101, "R8");

        // R5: 0101 straddling the boundary of 1101 and 0111
        send_word(4'b1101, "R5");
        send_word(4'b0111, "R5");

        // R9: dead prefix followed by a normal frame
        send_word(4'b0001, "R9");
        send_word(4'b1101, "R9");
        send_word(4'b1001, "R9");

        // R7: stalls inside a matching frame
        send(1'b1, 1'b0, "R7");
        send(1'b0, 1'b1, "R7");
        send(1'b1, 1'b1, "R7");
        send(1'b0, 1'b0, "R7");
        send(1'b0, 1'b1, "R7");
        send(1'b1, 1'b0, "R7");
        send(1'b0, 1'b1, "R7");
        send(1'b1, 1'b1, "R7");

        // R11: reset in mid frame discards the partial frame
        send(1'b1, 1'b0, "R11");
        send(1'b1, 1'b1, "R11");
        do_reset();
        send_word(4'b1001, "R11");

        // random stream with gaps
        for (int i = 0; i < 2000; i++) begin
            logic v, b;
            v = ($urandom % 5) != 0;
            b = $urandom % 2;
            send(v, b, frame_tag({m_sh[2:0], b}));
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule